// File: doc/BRIEF.md
# Divided-Clock Peripheral Strobe and NMI Controller

This block sits between a host processor and up to four peripheral microcontrollers. The host programs an 8-bit control word that holds a clock-divider shift, a transfer-direction bit and one enable per peripheral. While the shift is nonzero, an internal phase toggles at a fixed rate derived from the block clock. On every "asserting" phase the block raises a periodic NMI to the host, strobes the enabled chip selects and drives all direction lines. On the alternate phase it drops the NMI and the chip selects.

Host data writes are copied to every enabled peripheral as a one-cycle strobe together with the byte, but only in write direction. A data write in read direction is dropped and raises a sticky error flag, which is cleared by reading the control word. A control write in read direction clears the NMI at once and swallows the NMI of the first asserting phase that follows. This gives the peripheral one phase in which to answer. A restart begins after a short fixed delay. That delay grows by one full divided period when the write lands inside an asserting half.

Top module: `sbus_nmi_ctrl`

## Requirements
- R1: After reset, nmi_o, cs_o, rw_o, pwr_o, pdata_o and err_o are all 0, ctrl_rdata_o reads 0, the phase timer is stopped and the next phase event is an asserting one.
- R2: ctrl_rdata_o returns the control word last written, from the cycle after the write. The word layout is: bits 7:5 divider shift n, bit 4 direction (1 = read, 0 = write), bits 3:0 enables for peripherals 3..0.
- R3: With n nonzero, phase events occur every 2^(n-1) clock cycles, alternating between asserting and releasing.
- R4: After a control write with n nonzero, the first phase event (always an asserting one) occurs START_DLY cycles later. If the write arrives while an asserting half is in progress, a further 2^n cycles are added.
- R5: A control write with n = 0 stops the timer and drives nmi_o and cs_o to 0 in the next cycle. rw_o keeps its value, and no further phase events occur until the next control write with n nonzero.
- R6: At an asserting event, cs_o takes the enable bits 3:0. At a releasing event, cs_o goes to 0.
- R7: At each asserting event, all four rw_o bits take the direction bit. At no other time do they change.
- R8: In write direction, nmi_o is 1 after each asserting event and 0 after each releasing event.
- R9: A control write with bit 4 = 1 and n nonzero clears nmi_o in the next cycle and keeps it low through the first asserting event after the write. Later asserting events raise it.
- R10: A data write in write direction raises pwr_o with the enable bits in the next cycle, for one cycle, with pdata_o holding the byte.
- R11: A data write in read direction gives no pwr_o strobe and sets err_o, which stays set.
- R12: A control read clears err_o in the next cycle, unless an erroring data write happens in the same cycle; the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_rd_i | input | 1 | Control word read strobe (clears error) |
| ctrl_wdata_i | input | 8 | Control word to write |
| ctrl_rdata_o | output | 8 | Current control word |
| data_wr_i | input | 1 | Host data write strobe |
| data_wdata_i | input | 8 | Host data byte |
| nmi_o | output | 1 | NMI request to the host |
| cs_o | output | 4 | Gated chip selects, one per peripheral |
| rw_o | output | 4 | Direction level to each peripheral |
| pwr_o | output | 4 | Per-peripheral data write strobe |
| pdata_o | output | 8 | Data byte delivered with pwr_o |
| err_o | output | 1 | Sticky write-in-read-direction error |

## Verification
The divider is exercised at several shift values. Measuring the cycle distance to each NMI edge separates the start delay, the half-period length and the extra period added when a restart hits an asserting half. Read-direction restarts from a stopped state show the swallowed first NMI while chip selects and direction lines still follow the phase. A stop issued after read direction shows that the direction lines hold. Data writes in both directions, with and without a coincident control read, tell fan-out apart from the error path. A long stream of mixed control writes, data writes and reads is then compared each cycle against a behavioural model.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int NPORT   = 4;
    localparam int SHIFT_W = 3;
    localparam int DATA_W  = 8;
    localparam int CTRL_W  = SHIFT_W + 1 + NPORT;
    localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;

    // Control word: divider shift on top, direction, then per-port enables
    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic               rd_mode;
        logic [NPORT-1:0]   en;
    } ctrl_t;

endpackage

// File: rtl/sbus_ctrl_reg.sv
module sbus_ctrl_reg
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              err_set_i,
    output ctrl_t             ctrl_o,
    output logic              err_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  err;
    } reg_state_t;

    reg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.ctrl = ctrl_t'(wdata_i);
        end
        if (err_set_i) begin
            s_d.err = 1'b1;
        end else if (rd_i) begin
            s_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;
    assign err_o  = s_q.err;

endmodule

// File: rtl/sbus_phase_timer.sv
module sbus_phase_timer
    import sbus_pkg::*;
#(
    parameter int START_DLY = 1,
    parameter int CNT_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_i,
    input  logic [SHIFT_W-1:0] cfg_shift_i,
    input  logic [SHIFT_W-1:0] run_shift_i,
    input  logic               hold_i,
    output logic               evt_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        evt_o = 1'b0;
        if (cfg_wr_i) begin
            if (cfg_shift_i == '0) begin
                s_d.run = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.run = 1'b1;
                s_d.cnt = CNT_W'(START_DLY)
                        + (hold_i ? (CNT_W'(1) << cfg_shift_i) : '0);
            end
        end else if (s_q.run) begin
            if (s_q.cnt == CNT_W'(1)) begin
                evt_o   = 1'b1;
                s_d.cnt = CNT_W'(1) << (run_shift_i - SHIFT_W'(1));
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sbus_phase_gen.sv
module sbus_phase_gen
    import sbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic             cfg_stop_i,
    input  logic             cfg_rd_i,
    input  logic             run_rd_i,
    input  logic [NPORT-1:0] run_en_i,
    input  logic             evt_i,
    output logic             nmi_o,
    output logic [NPORT-1:0] cs_o,
    output logic [NPORT-1:0] rw_o,
    output logic             hold_o
);

    typedef struct packed {
        logic             nmi;
        logic [NPORT-1:0] cs;
        logic [NPORT-1:0] rw;
        logic             arm;   // next event is an asserting one
        logic             sup;   // swallow NMI on next asserting event
    } ph_state_t;

    ph_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_wr_i) begin
            s_d.arm = 1'b1;
            if (cfg_stop_i) begin
                s_d.nmi = 1'b0;
                s_d.cs  = '0;
                s_d.sup = 1'b0;
            end else begin
                s_d.sup = cfg_rd_i;
                if (cfg_rd_i) begin
                    s_d.nmi = 1'b0;
                end
            end
        end else if (evt_i) begin
            if (s_q.arm) begin
                s_d.rw  = {NPORT{run_rd_i}};
                s_d.nmi = ~s_q.sup;
                s_d.cs  = run_en_i;
                s_d.arm = 1'b0;
            end else begin
                s_d.nmi = 1'b0;
                s_d.cs  = '0;
                s_d.arm = 1'b1;
            end
            s_d.sup = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.arm <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign nmi_o  = s_q.nmi;
    assign cs_o   = s_q.cs;
    assign rw_o   = s_q.rw;
    assign hold_o = ~s_q.arm;

endmodule

// File: rtl/sbus_write_fanout.sv
module sbus_write_fanout
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_mode_i,
    input  logic [NPORT-1:0]  en_i,
    output logic [NPORT-1:0]  strobe_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);

    typedef struct packed {
        logic [NPORT-1:0]  strobe;
        logic [DATA_W-1:0] data;
    } fo_state_t;

    fo_state_t s_d, s_q;
    logic      accept;

    always_comb begin
        s_d        = s_q;
        accept     = wr_i & ~rd_mode_i;
        err_o      = wr_i & rd_mode_i;
        for (int p = 0; p < NPORT; p++) begin
            s_d.strobe[p] = accept & en_i[p];
        end
        if (accept) begin
            s_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe_o = s_q.strobe;
    assign data_o   = s_q.data;

endmodule

// File: rtl/sbus_nmi_ctrl.sv
module sbus_nmi_ctrl
    import sbus_pkg::*;
#(
    parameter int START_DLY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic              ctrl_rd_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_rdata_o,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_wdata_i,
    output logic              nmi_o,
    output logic [NPORT-1:0]  cs_o,
    output logic [NPORT-1:0]  rw_o,
    output logic [NPORT-1:0]  pwr_o,
    output logic [DATA_W-1:0] pdata_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(START_DLY + (1 << MAX_SHIFT) + 1);

    ctrl_t cfg_new;
    ctrl_t ctrl_q;
    logic  wr_err;
    logic  evt;
    logic  hold;

    assign cfg_new = ctrl_t'(ctrl_wdata_i);

    sbus_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctrl_wr_i),
        .wdata_i   (ctrl_wdata_i),
        .rd_i      (ctrl_rd_i),
        .err_set_i (wr_err),
        .ctrl_o    (ctrl_q),
        .err_o     (err_o)
    );

    sbus_phase_timer #(
        .START_DLY (START_DLY),
        .CNT_W     (CNT_W)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (ctrl_wr_i),
        .cfg_shift_i (cfg_new.shift),
        .run_shift_i (ctrl_q.shift),
        .hold_i      (hold),
        .evt_o       (evt)
    );

    sbus_phase_gen u_ph (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (ctrl_wr_i),
        .cfg_stop_i (cfg_new.shift == '0),
        .cfg_rd_i   (cfg_new.rd_mode),
        .run_rd_i   (ctrl_q.rd_mode),
        .run_en_i   (ctrl_q.en),
        .evt_i      (evt),
        .nmi_o      (nmi_o),
        .cs_o       (cs_o),
        .rw_o       (rw_o),
        .hold_o     (hold)
    );

    sbus_write_fanout u_fo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (data_wr_i),
        .wdata_i   (data_wdata_i),
        .rd_mode_i (ctrl_q.rd_mode),
        .en_i      (ctrl_q.en),
        .strobe_o  (pwr_o),
        .data_o    (pdata_o),
        .err_o     (wr_err)
    );

    assign ctrl_rdata_o = ctrl_q;

endmodule

// File: rtl/sbus_nmi_ctrl_chk.sv
module sbus_nmi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr_i,
    input logic       ctrl_rd_i,
    input logic [7:0] ctrl_wdata_i,
    input logic [7:0] ctrl_rdata_o,
    input logic       data_wr_i,
    input logic       nmi_o,
    input logic [3:0] cs_o,
    input logic [3:0] rw_o,
    input logic [3:0] pwr_o,
    input logic       err_o
);

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> ctrl_rdata_o == $past(ctrl_wdata_i)); // R2

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_wdata_i[7:5] == 3'd0) |=> (!nmi_o && cs_o == 4'd0)); // R5

    AST_STOP_KEEPS_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_wdata_i[7:5] == 3'd0) |=> $stable(rw_o)); // R5

    AST_RW_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_o == 4'h0) || (rw_o == 4'hF)); // R7

    AST_READ_NMI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_wdata_i[4] && ctrl_wdata_i[7:5] != 3'd0) |=> !nmi_o); // R9

    AST_FANOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && !ctrl_rdata_o[4]) |=> pwr_o == $past(ctrl_rdata_o[3:0])); // R10

    AST_READ_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && ctrl_rdata_o[4]) |=> (pwr_o == 4'd0 && err_o)); // R11

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_i && !(data_wr_i && ctrl_rdata_o[4])) |=> !err_o); // R12

endmodule

bind sbus_nmi_ctrl sbus_nmi_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_rd_i    (ctrl_rd_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .data_wr_i    (data_wr_i),
    .nmi_o        (nmi_o),
    .cs_o         (cs_o),
    .rw_o         (rw_o),
    .pwr_o        (pwr_o),
    .err_o        (err_o)
);

// File: tb/test_sbus_nmi_ctrl.sv
`timescale 1ns/1ps
module test_sbus_nmi_ctrl;

    localparam int START_DLY = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       ctrl_rd = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       nmi;
    logic [3:0] cs, rw, pwr;
    logic [7:0] pdata;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sbus_nmi_ctrl #(.START_DLY(START_DLY)) i_sbus_nmi_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_rd_i    (ctrl_rd),
        .ctrl_wdata_i (ctrl_wdata),
        .ctrl_rdata_o (ctrl_rdata),
        .data_wr_i    (data_wr),
        .data_wdata_i (data_wdata),
        .nmi_o        (nmi),
        .cs_o         (cs),
        .rw_o         (rw),
        .pwr_o        (pwr),
        .pdata_o      (pdata),
        .err_o        (err)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ctrl, m_err, m_nmi, m_cs, m_rw, m_pwr, m_pdata;
    int m_wait, m_run, m_arm, m_sup;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_err = 0; m_nmi = 0; m_cs = 0; m_rw = 0;
            m_pwr = 0; m_pdata = 0; m_wait = 0; m_run = 0; m_arm = 1; m_sup = 0;
        end else begin
            int n;
            int err_hit;
            err_hit = 0;
            m_pwr = 0;
            if (data_wr) begin
                if ((m_ctrl / 16) % 2 == 1) err_hit = 1;
                else begin
                    m_pwr = m_ctrl % 16;
                    m_pdata = data_wdata;
                end
            end
            if (err_hit != 0) m_err = 1;
            else if (ctrl_rd) m_err = 0;
            if (ctrl_wr) begin
                m_ctrl = ctrl_wdata;
                n = ctrl_wdata / 32;
                if (n == 0) begin
                    m_run = 0; m_nmi = 0; m_cs = 0; m_arm = 1; m_sup = 0;
                end else begin
                    m_wait = START_DLY + ((m_arm != 0) ? 0 : (1 << n));
                    m_run = 1; m_arm = 1;
                    m_sup = (ctrl_wdata / 16) % 2;
                    if (m_sup != 0) m_nmi = 0;
                end
            end else if (m_run != 0) begin
                m_wait--;
                if (m_wait == 0) begin
                    if (m_arm != 0) begin
                        m_rw = ((m_ctrl / 16) % 2 == 1) ? 15 : 0;
                        m_nmi = (m_sup != 0) ? 0 : 1;
                        m_cs = m_ctrl % 16;
                        m_arm = 0;
                    end else begin
                        m_nmi = 0; m_cs = 0; m_arm = 1;
                    end
                    m_sup = 0;
                    m_wait = 1 << ((m_ctrl / 32) - 1);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8",  int'(nmi),        m_nmi,  "model nmi");
            chk("R6",  int'(cs),         m_cs,   "model cs");
            chk("R7",  int'(rw),         m_rw,   "model rw");
            chk("R10", int'(pwr),        m_pwr,  "model strobe");
            if (m_pwr != 0) chk("R10", int'(pdata), m_pdata, "model data");
            chk("R11", int'(err),        m_err,  "model err");
            chk("R2",  int'(ctrl_rdata), m_ctrl, "model readback");
        end
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic drive(input bit cw, input logic [7:0] cd, input bit rd,
                         input bit dw, input logic [7:0] dd);
        ctrl_wr = cw; ctrl_wdata = cd; ctrl_rd = rd;
        data_wr = dw; data_wdata = dd;
        @(posedge clk);
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_rd = 1'b0; data_wr = 1'b0;
    endtask

    task automatic step(input int k);
        repeat (k) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic cycles_to_nmi(input logic lvl, output int k);
        k = 0;
        while (nmi !== lvl && k < 1000) begin
            step(1);
            k++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        int k;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1", int'(nmi), 0, "reset nmi");
        chk("R1", int'(cs), 0, "reset cs");
        chk("R1", int'(rw), 0, "reset rw");
        chk("R1", int'(pwr), 0, "reset strobe");
        chk("R1", int'(err), 0, "reset err");
        chk("R1", int'(ctrl_rdata), 0, "reset readback");

        // shift 1, write, enables 0011
        drive(1, 8'h23, 0, 0, 8'h00);
        cycles_to_nmi(1'b1, k); chk("R4", k, START_DLY, "start delay n=1");
        chk("R6", int'(cs), 3, "cs on asserting phase");
        cycles_to_nmi(1'b0, k); chk("R3", k, 1, "half period n=1");
        chk("R6", int'(cs), 0, "cs on releasing phase");

        // stop, then shift 3, write, all enables
        drive(1, 8'h03, 0, 0, 8'h00);
        chk("R5", int'(nmi), 0, "stop nmi");
        chk("R5", int'(cs), 0, "stop cs");
        drive(1, 8'h6F, 0, 0, 8'h00);
        cycles_to_nmi(1'b1, k); chk("R4", k, START_DLY, "start delay n=3");
        cycles_to_nmi(1'b0, k); chk("R3", k, 4, "half period n=3 fall");
        cycles_to_nmi(1'b1, k); chk("R3", k, 4, "half period n=3 rise");
        chk("R8", int'(nmi), 1, "write-mode nmi high");
        // restart inside asserting half: extra 8 cycles before first event
        drive(1, 8'h6F, 0, 0, 8'h00);
        cycles_to_nmi(1'b0, k); chk("R4", k, START_DLY + 8 + 4, "extra period on restart");

        // read direction restart from stopped state
        drive(1, 8'h00, 0, 0, 8'h00);
        drive(1, 8'h3F, 0, 0, 8'h00);
        chk("R9", int'(nmi), 0, "read write clears nmi");
        step(1);
        chk("R9", int'(nmi), 0, "first asserting nmi swallowed");
        chk("R6", int'(cs), 15, "cs despite swallowed nmi");
        chk("R7", int'(rw), 15, "rw follows read direction");
        step(1);
        chk("R6", int'(cs), 0, "cs released");
        step(1);
        chk("R9", int'(nmi), 1, "second asserting nmi raised");

        // stop keeps rw
        drive(1, 8'h0F, 0, 0, 8'h00);
        chk("R5", int'(rw), 15, "stop keeps rw");
        step(10);
        chk("R5", int'(nmi), 0, "no events while stopped nmi");
        chk("R5", int'(cs), 0, "no events while stopped cs");
        chk("R7", int'(rw), 15, "rw unchanged while stopped");

        // write fan-out
        drive(1, 8'h25, 0, 0, 8'h00);
        drive(0, 8'h00, 0, 1, 8'hA5);
        chk("R10", int'(pwr), 5, "strobe enabled ports");
        chk("R10", int'(pdata), 8'hA5, "strobe data");
        step(1);
        chk("R10", int'(pwr), 0, "strobe one cycle");

        // write in read direction
        drive(1, 8'h1A, 0, 0, 8'h00);
        drive(0, 8'h00, 0, 1, 8'h3C);
        chk("R11", int'(pwr), 0, "no strobe in read dir");
        chk("R11", int'(err), 1, "error set");
        step(3);
        chk("R11", int'(err), 1, "error sticky");
        drive(0, 8'h00, 1, 0, 8'h00);
        chk("R12", int'(err), 0, "read clears error");
        chk("R2", int'(ctrl_rdata), 8'h1A, "readback");
        drive(0, 8'h00, 1, 1, 8'h11);
        chk("R12", int'(err), 1, "set wins over clear");
        drive(0, 8'h00, 1, 0, 8'h00);

        // mixed stream against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8)
                drive(1, {3'($urandom_range(0, 3)), 5'($urandom_range(0, 31))}, 0, 0, 8'h00);
            else if (r < 25)
                drive(0, 8'h00, ($urandom_range(0, 3) == 0), 1, 8'($urandom_range(0, 255)));
            else if (r < 32)
                drive(0, 8'h00, 1, 0, 8'h00);
            else
                step(1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule